// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Access Port

This block is a serial test access port for a synchronous memory. Its 16-state controller follows the standard test-mode-select state graph. It selects one of three data registers or its 3-bit instruction register and places it between the serial input and the serial output. The data registers are a one-bit bypass cell, a 32-bit identification word, and a boundary register that only samples. The boundary register takes a parallel snapshot of the memory's pin ring during Capture-DR. It never drives the pins.

The port does not follow the standard in full. The external-test and sample-with-high-Z instructions only capture the pins, and they raise a signal that tells the memory to float its output drivers. The sample instruction captures without touching the drivers. Update-DR has no effect. The three unassigned instruction codes select the bypass cell, so the chain stays usable.

Top module: `scan_port`

## Requirements
- R1: From any controller state, five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset. The next rising edge taken in that state makes IDCODE (001) the active instruction.
- R2: `tdo_en` is high only while the controller is in Shift-IR or Shift-DR. Both `tdo` and `tdo_en` change only on the falling `tck` edge. `tdo_en` is low after reset.
- R3: In Capture-IR the instruction shift register loads 3'b001: bit 0 is 1 and bits 2:1 are 0.
- R4: Each shift moves `tdi` into the most significant bit of the selected register. `tdo` presents bit 0, so bits leave least significant first.
- R5: Under IDCODE the data register is 32 bits long and captures the value {revision[3:0], depth[4:0], width[4:0], device[5:0], vendor[10:0], 1'b1}, with bit 0 always 1.
- R6: Codes 111, 011, 101 and 110 select a one-bit bypass register that captures 0. A shift of n bits returns 0 followed by the first n-1 input bits.
- R7: Codes 000, 010 and 100 select the BSR_LEN-bit boundary register. In Capture-DR it loads `pin_snap`, with bit i of `pin_snap` in boundary bit i.
- R8: `drv_off` is high exactly while the active instruction is 000 or 010. It is low after reset.
- R9: A newly shifted instruction becomes active only on the rising edge taken in Update-IR. Until then `drv_off` keeps its previous value.
- R10: Update-DR changes neither `drv_off` nor the boundary contents. A path through Pause-DR and Exit2-DR back to Shift-DR keeps the shifted contents without a new capture.
- R11: A rising edge with `rst_n` low puts the controller in Test-Logic-Reset and makes IDCODE active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| pin_snap | input | BSR_LEN | Parallel snapshot of the memory pin ring |
| tdo | output | 1 | Serial data out, high-impedance when not enabled |
| tdo_en | output | 1 | Output enable for `tdo` |
| drv_off | output | 1 | Request to float the memory output drivers |

## Verification
The bench builds the port with a 12-bit boundary register and its own identification fields. This keeps every boundary scan short enough to compare whole against an arithmetic pattern. All eight instruction codes are loaded in turn, so each decode path (boundary, identification, bypass, reserved) is scanned with its own snapshot and data pattern. The short chain also makes it cheap to run the pause-and-resume path, and to force a reset by holding `tms` high from deep inside both the IR and DR branches.

// File: rtl/tap_pkg.sv
// Shared definitions for the test access port: controller states,
// instruction codes and the data-register selection rule.
// Assumes a 3-bit instruction register.
package tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
        ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
    } tap_state_e;

    typedef enum logic [1:0] { PATH_BYP, PATH_ID, PATH_BND } dr_path_e;

    localparam logic [IR_W-1:0] OP_EXT_HIZ  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDENT    = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMP_HIZ = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 3'b100;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 3'b001;

    // Map an instruction to the data register it places in the chain
    function automatic dr_path_e path_of(input logic [IR_W-1:0] op);
        case (op)
            OP_EXT_HIZ, OP_SAMP_HIZ, OP_SAMPLE: path_of = PATH_BND;
            OP_IDENT:                           path_of = PATH_ID;
            default:                            path_of = PATH_BYP;
        endcase
    endfunction

    // True when the instruction asks the memory to float its drivers
    function automatic logic floats_pins(input logic [IR_W-1:0] op);
        floats_pins = (op == OP_EXT_HIZ) || (op == OP_SAMP_HIZ);
    endfunction

endpackage

// File: rtl/tap_fsm.sv
// Sixteen-state controller driven by tms on the rising tck edge.
// Assumes rst_n is synchronous to tck.
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    // Next-state function of the standard state graph
    always_comb begin
        case (state)
            ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     nxt = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: nxt = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   nxt = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: nxt = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
            default:     nxt = ST_RESET;
        endcase
    end

    // State register
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

endmodule

// File: rtl/tap_ir.sv
// Instruction register: a capture/shift stage plus the active
// instruction, which changes only in Update-IR or on reset.
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_shreg,
    output logic [IR_W-1:0] active_op
);

    // Capture the fixed pattern, then shift toward bit 0
    always_ff @(posedge tck) begin
        if (!rst_n)                    ir_shreg <= '0;
        else if (state == ST_IR_CAP)   ir_shreg <= IR_CAPTURE;
        else if (state == ST_IR_SHIFT) ir_shreg <= {tdi, ir_shreg[IR_W-1:1]};
    end

    // Hold the active instruction; reload IDCODE in Test-Logic-Reset
    always_ff @(posedge tck) begin
        if (!rst_n || state == ST_RESET) active_op <= OP_IDENT;
        else if (state == ST_IR_UPD)     active_op <= ir_shreg;
    end

endmodule

// File: rtl/tap_dr.sv
// Data registers: bypass cell, identification word and a capture-only
// boundary register. Only the register the instruction selects moves.
module tap_dr
    import tap_pkg::*;
#(
    parameter int              BSR_LEN  = 75,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1
) (
    input  logic               tck,
    input  logic               rst_n,
    input  tap_state_e         state,
    input  logic               tdi,
    input  logic [IR_W-1:0]    active_op,
    input  logic [BSR_LEN-1:0] pin_snap,
    output logic               byp_bit,
    output logic               dr_lsb
);

    dr_path_e           path;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] bnd_q;
    logic               cap, sh;

    assign path = path_of(active_op);
    assign cap  = (state == ST_DR_CAP);
    assign sh   = (state == ST_DR_SHIFT);

    // Bypass cell: captures 0, shifts tdi through
    always_ff @(posedge tck) begin
        if (!rst_n)                         byp_bit <= 1'b0;
        else if (path == PATH_BYP && cap)   byp_bit <= 1'b0;
        else if (path == PATH_BYP && sh)    byp_bit <= tdi;
    end

    // Identification word: loads the fixed code, shifts toward bit 0
    always_ff @(posedge tck) begin
        if (!rst_n)                         id_q <= '0;
        else if (path == PATH_ID && cap)    id_q <= {ID_VALUE[ID_W-1:1], 1'b1};
        else if (path == PATH_ID && sh)     id_q <= {tdi, id_q[ID_W-1:1]};
    end

    // Boundary register: snapshot on capture, no update stage
    always_ff @(posedge tck) begin
        if (!rst_n)                         bnd_q <= '0;
        else if (path == PATH_BND && cap)   bnd_q <= pin_snap;
        else if (path == PATH_BND && sh)    bnd_q <= {tdi, bnd_q[BSR_LEN-1:1]};
    end

    // Serial output of the selected register
    always_comb begin
        case (path)
            PATH_ID:  dr_lsb = id_q[0];
            PATH_BND: dr_lsb = bnd_q[0];
            default:  dr_lsb = byp_bit;
        endcase
    end

endmodule

// File: rtl/scan_port.sv
// Top of the reduced test access port. Builds the identification word
// from its fields and retimes tdo and its enable to the falling edge.
// Assumes rst_n is synchronous to tck.
module scan_port
    import tap_pkg::*;
#(
    parameter int          BSR_LEN   = 75,
    parameter logic [3:0]  REV_FLD   = 4'h2,
    parameter logic [4:0]  DEPTH_FLD = 5'h0B,
    parameter logic [4:0]  WIDTH_FLD = 5'h04,
    parameter logic [5:0]  DEV_FLD   = 6'h11,
    parameter logic [10:0] VEND_FLD  = 11'h3C6
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_snap,
    output logic               tdo,
    output logic               tdo_en,
    output logic               drv_off
);

    localparam logic [ID_W-1:0] ID_VALUE =
        {REV_FLD, DEPTH_FLD, WIDTH_FLD, DEV_FLD, VEND_FLD, 1'b1};

    tap_state_e      state;
    logic [IR_W-1:0] ir_shreg;
    logic [IR_W-1:0] active_op;
    logic            byp_bit;
    logic            dr_lsb;
    logic            tdo_q;

    tap_fsm u_fsm (
        .tck(tck), .rst_n(rst_n), .tms(tms), .state(state)
    );

    tap_ir u_ir (
        .tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
        .ir_shreg(ir_shreg), .active_op(active_op)
    );

    tap_dr #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) u_dr (
        .tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
        .active_op(active_op), .pin_snap(pin_snap),
        .byp_bit(byp_bit), .dr_lsb(dr_lsb)
    );

    // Falling-edge output stage: serial bit and its enable
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo_q  <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_q  <= (state == ST_IR_SHIFT) ? ir_shreg[0] : dr_lsb;
            tdo_en <= (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
        end
    end

    assign tdo     = tdo_en ? tdo_q : 1'bz;
    assign drv_off = floats_pins(active_op);

endmodule

// File: rtl/tap_chk.sv
// Property checker for scan_port, attached with bind.
module tap_chk
    import tap_pkg::*;
(
    input logic            tck,
    input logic            rst_n,
    input logic            tms,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_shreg,
    input logic [IR_W-1:0] active_op,
    input logic            byp_bit,
    input logic            tdo_en,
    input logic            drv_off
);

    logic [2:0] hi_run;

    // Count consecutive tms-high edges, saturating at five
    always_ff @(posedge tck) begin
        if (!rst_n)           hi_run <= '0;
        else if (!tms)        hi_run <= '0;
        else if (hi_run != 5) hi_run <= hi_run + 3'd1;
    end

    // R1
    five_high_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (hi_run == 3'd5) |-> (state == ST_RESET));

    // R2
    tdo_en_quiet_chk: assert property (@(negedge tck) disable iff (!rst_n)
        (state != ST_IR_SHIFT && state != ST_DR_SHIFT) |=> !tdo_en);

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_IR_CAP) |=> (ir_shreg[1:0] == 2'b01));

    // R6
    bypass_zero_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_DR_CAP && path_of(active_op) == PATH_BYP) |=> !byp_bit);

    // R9
    drv_off_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_IR_UPD && state != ST_RESET) |=> $stable(drv_off));

    // R1
    reset_ident_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_RESET) |=> (active_op == OP_IDENT && !drv_off));

endmodule

bind scan_port tap_chk u_chk (
    .tck(tck), .rst_n(rst_n), .tms(tms), .state(state),
    .ir_shreg(ir_shreg), .active_op(active_op), .byp_bit(byp_bit),
    .tdo_en(tdo_en), .drv_off(drv_off)
);

// File: tb/tb_scan_port.sv
`timescale 1ns/1ps
module tb_scan_port;

    localparam int          BL   = 12;
    localparam logic [3:0]  REV  = 4'h9;
    localparam logic [4:0]  DEP  = 5'h15;
    localparam logic [4:0]  WID  = 5'h0A;
    localparam logic [5:0]  DEV  = 6'h2D;
    localparam logic [10:0] VEN  = 11'h5B3;
    localparam logic [31:0] EXP_ID = {REV, DEP, WID, DEV, VEN, 1'b1};

    logic          tck = 1'b0;
    logic          rst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic [BL-1:0] pin_snap = '0;
    logic          tdo, tdo_en, drv_off;

    int checks = 0;
    int errors = 0;
    logic smp_tdo, smp_en, en_all, exp_dis;

    scan_port #(.BSR_LEN(BL), .REV_FLD(REV), .DEPTH_FLD(DEP), .WIDTH_FLD(WID),
                .DEV_FLD(DEV), .VEND_FLD(VEN)) dut (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .pin_snap(pin_snap),
        .tdo(tdo), .tdo_en(tdo_en), .drv_off(drv_off)
    );

    always #2.5 tck = ~tck;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive after the falling edge, sample late in the low phase, end at the rising edge
    task automatic step(input logic m, input logic d);
        @(negedge tck);
        tms = m;
        tdi = d;
        #2;
        smp_tdo = tdo;
        smp_en  = tdo_en;
        @(posedge tck);
    endtask

    task automatic shift(input int n, input logic [127:0] din, output logic [127:0] dout);
        dout = '0;
        en_all = 1'b1;
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i]);
            dout[i] = smp_tdo;
            en_all &= smp_en;
        end
    endtask

    task automatic ir_load(input logic [2:0] code);
        logic [127:0] cap;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        shift(3, {125'd0, code}, cap);
        check("R3 capture-IR pattern", cap, 128'd1);
        #0.5;
        check("R9 drv_off before Update-IR", {127'd0, drv_off}, {127'd0, exp_dis});
        step(1, 0); step(0, 0);
        #0.5;
        exp_dis = (code == 3'b000) || (code == 3'b010);
    endtask

    task automatic dr_scan(input int n, input logic [127:0] din, output logic [127:0] dout);
        step(1, 0); step(0, 0); step(0, 0);
        shift(n, din, dout);
        step(1, 0); step(0, 0);
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] out, pat, snap;
        exp_dis = 1'b0;
        repeat (3) @(posedge tck);
        #1;
        check("R2 tdo_en after reset", {127'd0, tdo_en}, 128'd0);
        check("R11 R8 drv_off after reset", {127'd0, drv_off}, 128'd0);
        @(negedge tck);
        rst_n = 1'b1;
        step(0, 0);

        // Default instruction after reset is IDCODE
        dr_scan(32, '0, out);
        check("R5 R11 identification word", out, {96'd0, EXP_ID});
        check("R2 tdo_en during Shift-DR", {127'd0, en_all}, 128'd1);
        check("R2 tdo_en outside shift", {127'd0, smp_en}, 128'd0);

        // Falling-edge timing of the output stage
        step(1, 0); step(0, 0); step(0, 0);
        #0.5;
        check("R2 tdo_en before falling edge", {127'd0, tdo_en}, 128'd0);
        @(negedge tck);
        #0.5;
        check("R2 tdo_en after falling edge", {127'd0, tdo_en}, 128'd1);
        check("R4 first bit is bit 0", {127'd0, tdo}, 128'd1);
        step(1, 0); step(1, 0); step(0, 0);

        // Sweep every instruction code
        for (int c = 0; c < 8; c++) begin
            ir_load(c[2:0]);
            check("R8 drv_off for code", {127'd0, drv_off}, {127'd0, exp_dis});
            snap = {116'd0, (12'h5A3 ^ (12'h111 * c[11:0]))};
            pin_snap = snap[BL-1:0];
            if (c == 0 || c == 2 || c == 4) begin
                dr_scan(BL, 128'hF0F, out);
                check("R7 boundary capture", out, snap);
            end else if (c == 1) begin
                dr_scan(32, '0, out);
                check("R5 identification via IDCODE", out, {96'd0, EXP_ID});
            end else begin
                pat = {120'd0, 8'h35 ^ c[7:0]};
                dr_scan(8, pat, out);
                check("R6 bypass path", out, {pat[126:0], 1'b0} & 128'hFF);
            end
        end

        // Pause and resume keep shifted contents; Update-DR is inert
        ir_load(3'b100);
        pat = 128'hB6D;
        step(1, 0); step(0, 0); step(0, 0);
        shift(BL, pat, out);
        step(0, 0); step(0, 0); step(1, 0); step(0, 0);
        shift(BL, '0, out);
        check("R10 R4 contents kept through pause", out, pat);
        step(1, 0);
        #0.5;
        check("R10 drv_off through Update-DR", {127'd0, drv_off}, 128'd0);
        step(0, 0);

        // Five tms-high edges from inside Shift-IR
        ir_load(3'b000);
        check("R8 drv_off for EXTEST", {127'd0, drv_off}, 128'd1);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int k = 0; k < 5; k++) step(1, 0);
        step(0, 0);
        #0.5;
        check("R1 reset from Shift-IR", {127'd0, drv_off}, 128'd0);
        exp_dis = 1'b0;
        dr_scan(32, '0, out);
        check("R1 IDCODE active after reset", out, {96'd0, EXP_ID});

        // Five tms-high edges from Pause-DR
        ir_load(3'b010);
        step(1, 0); step(0, 0); step(1, 0); step(0, 0);
        for (int k = 0; k < 5; k++) step(1, 0);
        step(0, 0);
        #0.5;
        check("R1 reset from Pause-DR", {127'd0, drv_off}, 128'd0);
        exp_dis = 1'b0;

        // Synchronous reset mid-operation
        ir_load(3'b000);
        @(negedge tck);
        rst_n = 1'b0;
        @(posedge tck);
        #0.5;
        check("R11 reset clears drv_off", {127'd0, drv_off}, 128'd0);
        @(negedge tck);
        rst_n = 1'b1;
        exp_dis = 1'b0;
        step(0, 0);
        dr_scan(32, '0, out);
        check("R11 IDCODE after reset", out, {96'd0, EXP_ID});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule